// File: doc/BRIEF.md
# Per-Core Store Queue with Ordering Barrier

This block sits between one core's memory interface and a shared single-port memory. It gives the core total-store-order semantics. A store is taken into a small private queue and is finished as far as the core is concerned. It becomes visible to other cores only when the queue writes it into shared memory. The queue writes its oldest entry through a request/grant port that feeds an external memory arbiter. It writes one entry per granted cycle, in the order the stores arrived.

Loads from the core are looked up in the queue combinationally. If one or more live entries carry the load address, the youngest of them supplies the data. Otherwise the data comes from shared memory, even when older stores to other addresses are still waiting in the queue.

A barrier request and a locked read-modify-write request both wait for the queue to empty. While either is raised, new stores are held off. The matching done signal rises in the first cycle in which no entry remains. The core issues no further load or atomic access until it sees that signal.

Top module: `tso_store_queue`

## Requirements
- R1: A store presented with `storeValid` high in a cycle where `storeReady` is high is accepted at that clock edge. From the next cycle it is held in the queue, and shared memory at that address keeps its old value until the entry is drained.
- R2: Entries drain in arrival order. `drainReq` is high whenever the queue holds an entry, and `drainAddr`/`drainData` always present the oldest entry.
- R3: The oldest entry is removed only at a clock edge where `drainReq` and `drainGrant` are both high. Without a grant, `drainAddr` and `drainData` stay unchanged.
- R4: When a live entry matches `loadAddr`, `loadHit` is 1 and `loadData` carries that entry's data.
- R5: When several live entries match `loadAddr`, `loadData` carries the data of the most recently accepted one.
- R6: When no live entry matches, `loadHit` is 0 and `loadData` equals `memRdData`, whatever other addresses are buffered.
- R7: The queue holds DEPTH (default 4) entries. With DEPTH entries held, `storeReady` is 0 and a presented store is not taken. After one entry drains, `storeReady` returns to 1.
- R8: While `fenceReq` is high, `storeReady` is 0. `fenceDone` is 1 exactly in the cycles where `fenceReq` is high and the queue is empty, so it first rises in the cycle after the last granted drain.
- R9: `lockReq` follows the same rule through `lockGo`. With an already empty queue, `lockGo` is 1 in the same cycle as `lockReq`. `fenceDone` stays 0 when only `lockReq` is raised.
- R10: Reset empties the queue: `drainReq` is 0, `storeReady` is 1, and no entry from before reset forwards to a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| storeValid | input | 1 | Core presents a store |
| storeReady | output | 1 | Queue can take the store this cycle |
| storeAddr | input | ADDR_W | Store address |
| storeData | input | DATA_W | Store data |
| loadAddr | input | ADDR_W | Load lookup address |
| memRdData | input | DATA_W | Shared-memory read data for loadAddr |
| loadData | output | DATA_W | Load result (forwarded or from memory) |
| loadHit | output | 1 | Load result was forwarded from the queue |
| drainReq | output | 1 | Write request to the memory arbiter |
| drainGrant | input | 1 | Arbiter accepts the write this cycle |
| drainAddr | output | ADDR_W | Address of the oldest entry |
| drainData | output | DATA_W | Data of the oldest entry |
| fenceReq | input | 1 | Barrier request |
| fenceDone | output | 1 | Barrier may complete |
| lockReq | input | 1 | Locked read-modify-write request |
| lockGo | output | 1 | Locked access may proceed |

## Verification
Loads are tried with four address patterns. An address held once in the queue shows that forwarding works. An address held twice shows whether the youngest or the oldest copy wins. An address that is not buffered while others are shows that unrelated stores do not block the load. An address whose memory value is stale while its store is buffered shows that other cores cannot yet see the write. Drains are run with the grant withheld and then given one pulse at a time, which separates grant-gated removal from free-running removal. Final memory contents after two stores to one address reveal the drain order. The barrier and lock are each counted from request to done against the number of held entries, and the lock is also raised on an empty queue to check that it completes at once.

// File: rtl/tso_sb_pkg.sv
package tso_sb_pkg;
  // Strobes from the queue control to the entry storage.
  typedef struct packed {
    logic push;  // write the incoming store at the tail
    logic pop;   // oldest entry leaves this edge
  } sbStrobes_t;
endpackage

// File: rtl/tso_sb_ctrl.sv
module tso_sb_ctrl
  import tso_sb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             storeValid,
  input  logic             drainGrant,
  input  logic             fenceReq,
  input  logic             lockReq,
  output logic             storeReady,
  output logic             drainReq,
  output logic             fenceDone,
  output logic             lockGo,
  output sbStrobes_t       strobes,
  output logic [PTR_W-1:0] headIdx,
  output logic [PTR_W-1:0] tailIdx,
  output logic [CNT_W-1:0] count
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic isEmpty, isFull, syncPending;

  assign isEmpty     = (count == '0);
  assign isFull      = (count == FULL_CNT);
  assign syncPending = fenceReq || lockReq;

  assign storeReady  = !isFull && !syncPending;
  assign drainReq    = !isEmpty;
  assign fenceDone   = fenceReq && isEmpty;
  assign lockGo      = lockReq && isEmpty;

  assign strobes.push = storeValid && storeReady;
  assign strobes.pop  = drainReq && drainGrant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headIdx <= '0;
      tailIdx <= '0;
      count   <= '0;
    end else begin
      if (strobes.pop)
        headIdx <= (headIdx == LAST_IDX) ? '0 : headIdx + 1'b1;
      if (strobes.push)
        tailIdx <= (tailIdx == LAST_IDX) ? '0 : tailIdx + 1'b1;
      case ({strobes.push, strobes.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: never take a store into a full queue
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.push |-> (count < FULL_CNT));

  // R3: occupancy only falls at an edge that carried a grant
  assert_drop_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(drainReq && drainGrant) |=> (count >= $past(count)));

  // R8/R9: barrier or lock keeps new stores out
  assert_sync_blocks_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fenceReq || lockReq) |-> !strobes.push);
endmodule

// File: rtl/tso_sb_data.sv
module tso_sb_data
  import tso_sb_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  sbStrobes_t        strobes,
  input  logic [PTR_W-1:0]  headIdx,
  input  logic [PTR_W-1:0]  tailIdx,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic [DATA_W-1:0] storeData,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] drainAddr,
  output logic [DATA_W-1:0] drainData,
  output logic [DATA_W-1:0] loadData,
  output logic              loadHit
);
  logic [ADDR_W-1:0] addrQ [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];
  logic [DEPTH-1:0]  ageMatch;   // indexed by age, 0 = oldest
  logic [DATA_W-1:0] ageData [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.push) begin
      addrQ[tailIdx] <= storeAddr;
      dataQ[tailIdx] <= storeData;
    end
  end

  assign drainAddr = addrQ[headIdx];
  assign drainData = dataQ[headIdx];

  // One comparator per age position, slot found by rotating from the head.
  for (genvar age = 0; age < DEPTH; age++) begin : g_age
    logic [PTR_W:0]   slotWide;
    logic [PTR_W-1:0] slot;
    assign slotWide = {1'b0, headIdx} + (PTR_W+1)'(age);
    assign slot = (slotWide >= (PTR_W+1)'(DEPTH))
                  ? PTR_W'(slotWide - (PTR_W+1)'(DEPTH)) : PTR_W'(slotWide);
    assign ageMatch[age] = (CNT_W'(age) < count) && (addrQ[slot] == loadAddr);
    assign ageData[age]  = dataQ[slot];
  end

  // Youngest match wins: later ages overwrite earlier ones.
  always_comb begin
    loadHit  = 1'b0;
    loadData = memRdData;
    for (int age = 0; age < DEPTH; age++) begin
      if (ageMatch[age]) begin
        loadHit  = 1'b1;
        loadData = ageData[age];
      end
    end
  end

  // R6: with no live match the result is the memory data
  always_comb begin
    if (ageMatch == '0)
      assert_miss_reads_memory_R6: assert (loadData == memRdData || $isunknown(ageMatch));
  end
endmodule

// File: rtl/tso_store_queue.sv
module tso_store_queue
  import tso_sb_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              storeValid,
  output logic              storeReady,
  input  logic [ADDR_W-1:0] storeAddr,
  input  logic [DATA_W-1:0] storeData,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] loadData,
  output logic              loadHit,
  output logic              drainReq,
  input  logic              drainGrant,
  output logic [ADDR_W-1:0] drainAddr,
  output logic [DATA_W-1:0] drainData,
  input  logic              fenceReq,
  output logic              fenceDone,
  input  logic              lockReq,
  output logic              lockGo
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  sbStrobes_t       strobes;
  logic [PTR_W-1:0] headIdx, tailIdx;
  logic [CNT_W-1:0] count;

  tso_sb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .storeValid(storeValid), .drainGrant(drainGrant),
    .fenceReq(fenceReq), .lockReq(lockReq), .storeReady(storeReady),
    .drainReq(drainReq), .fenceDone(fenceDone), .lockGo(lockGo),
    .strobes(strobes), .headIdx(headIdx), .tailIdx(tailIdx), .count(count)
  );

  tso_sb_data #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .strobes(strobes), .headIdx(headIdx), .tailIdx(tailIdx),
    .count(count), .storeAddr(storeAddr), .storeData(storeData),
    .loadAddr(loadAddr), .memRdData(memRdData), .drainAddr(drainAddr),
    .drainData(drainData), .loadData(loadData), .loadHit(loadHit)
  );

  // R3: an ungranted head entry stays on the drain port
  assert_head_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (drainReq && !drainGrant) |=> (drainReq && $stable(drainAddr) && $stable(drainData)));

  // R8: barrier completion only with nothing left to write
  assert_fence_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fenceDone |-> !drainReq);

  // R9: lock completion only with nothing left to write
  assert_lock_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lockGo |-> !drainReq);
endmodule

// File: tb/tso_store_queue_test.sv
module tso_store_queue_test;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic storeValid = 1'b0;
  logic storeReady;
  logic [ADDR_W-1:0] storeAddr = '0;
  logic [DATA_W-1:0] storeData = '0;
  logic [ADDR_W-1:0] loadAddr = '0;
  logic [DATA_W-1:0] memRdData;
  logic [DATA_W-1:0] loadData;
  logic loadHit, drainReq, drainGrant;
  logic [ADDR_W-1:0] drainAddr;
  logic [DATA_W-1:0] drainData;
  logic fenceReq = 1'b0, lockReq = 1'b0;
  logic fenceDone, lockGo;
  logic grantEn = 1'b0;

  int checks = 0;
  int fails = 0;

  logic [DATA_W-1:0] mem [256];

  always #2 clk = ~clk;  // 250 MHz

  assign drainGrant = grantEn;
  assign memRdData  = mem[loadAddr[7:0]];

  always @(posedge clk)
    if (rst_n && drainReq && drainGrant) mem[drainAddr[7:0]] <= drainData;

  tso_store_queue uut (
    .clk(clk), .rst_n(rst_n), .storeValid(storeValid), .storeReady(storeReady),
    .storeAddr(storeAddr), .storeData(storeData), .loadAddr(loadAddr),
    .memRdData(memRdData), .loadData(loadData), .loadHit(loadHit),
    .drainReq(drainReq), .drainGrant(drainGrant), .drainAddr(drainAddr),
    .drainData(drainData), .fenceReq(fenceReq), .fenceDone(fenceDone),
    .lockReq(lockReq), .lockGo(lockGo)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic doStore(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    storeValid = 1'b1; storeAddr = a; storeData = d;
    #1;
    while (!storeReady) begin @(negedge clk); #1; end
    @(negedge clk);
    storeValid = 1'b0;
    #1;
  endtask

  task automatic grantPulses(input int n);
    @(negedge clk);
    grantEn = 1'b1;
    repeat (n) @(negedge clk);
    grantEn = 1'b0;
    #1;
  endtask

  task automatic testReset();
    doReset();
    check("R10 drainReq after reset", 32'(drainReq), 32'd0);
    check("R10 storeReady after reset", 32'(storeReady), 32'd1);
    check("R8 fenceDone idle", 32'(fenceDone), 32'd0);
  endtask

  task automatic testForward();
    doStore(16'h0010, 32'h1111_0001);
    doStore(16'h0020, 32'h2222_0002);
    loadAddr = 16'h0010; #1;
    check("R4 hit on buffered addr", 32'(loadHit), 32'd1);
    check("R4 forwarded data", loadData, 32'h1111_0001);
    check("R1 memory still old", mem[8'h10], 32'hA000_0010);
    loadAddr = 16'h0030; #1;
    check("R6 miss hit flag", 32'(loadHit), 32'd0);
    check("R6 miss reads memory", loadData, 32'hA000_0030);
    check("R2 head address", 32'(drainAddr), 32'h0010);
    check("R2 drainReq with entries", 32'(drainReq), 32'd1);
  endtask

  task automatic testYoungest();
    doStore(16'h0010, 32'h1111_0003);
    loadAddr = 16'h0010; #1;
    check("R5 youngest match", loadData, 32'h1111_0003);
  endtask

  task automatic testFull();
    doStore(16'h0040, 32'h4444_0004);
    check("R7 not ready when full", 32'(storeReady), 32'd0);
    @(negedge clk);
    storeValid = 1'b1; storeAddr = 16'h0050; storeData = 32'h5555_0005;
    repeat (3) begin
      @(negedge clk); #1;
      check("R3 head addr held", 32'(drainAddr), 32'h0010);
      check("R3 head data held", drainData, 32'h1111_0001);
    end
    storeValid = 1'b0;
    grantPulses(1);
    check("R3 granted write landed", mem[8'h10], 32'h1111_0001);
    check("R2 next head", 32'(drainAddr), 32'h0020);
    check("R7 ready after drain", 32'(storeReady), 32'd1);
    loadAddr = 16'h0050; #1;
    check("R7 store while full not taken", 32'(loadHit), 32'd0);
    loadAddr = 16'h0010; #1;
    check("R5 buffered copy beats memory", loadData, 32'h1111_0003);
  endtask

  task automatic testFence();
    int seen = 0;
    @(negedge clk);
    fenceReq = 1'b1; #1;
    check("R8 fence waits", 32'(fenceDone), 32'd0);
    check("R8 stores held off", 32'(storeReady), 32'd0);
    @(negedge clk);
    grantEn = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk); #1;
      if (fenceDone) begin seen = k; break; end
    end
    check("R8 done after three drains", 32'(seen), 32'd3);
    grantEn = 1'b0; fenceReq = 1'b0;
    check("R2 final value in order", mem[8'h10], 32'h1111_0003);
    check("R2 other drained", mem[8'h40], 32'h4444_0004);
    loadAddr = 16'h0010; #1;
    check("R6 after drain from memory", 32'(loadHit), 32'd0);
  endtask

  task automatic testLock();
    int seen = 0;
    doStore(16'h0060, 32'h6666_0006);
    doStore(16'h0070, 32'h7777_0007);
    @(negedge clk);
    lockReq = 1'b1; #1;
    check("R9 lock waits", 32'(lockGo), 32'd0);
    check("R9 fence flag stays low", 32'(fenceDone), 32'd0);
    @(negedge clk);
    grantEn = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk); #1;
      if (lockGo) begin seen = k; break; end
    end
    check("R9 go after two drains", 32'(seen), 32'd2);
    grantEn = 1'b0; lockReq = 1'b0;
    @(negedge clk);
    lockReq = 1'b1; #1;
    check("R9 empty queue immediate go", 32'(lockGo), 32'd1);
    @(negedge clk);
    lockReq = 1'b0;
  endtask

  task automatic testResetClears();
    doStore(16'h0080, 32'h8888_0008);
    doReset();
    loadAddr = 16'h0080; #1;
    check("R10 no forward after reset", 32'(loadHit), 32'd0);
    check("R10 queue empty", 32'(drainReq), 32'd0);
    check("R1 dropped store never written", mem[8'h80], 32'hA000_0080);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + 32'(i);
    testReset();
    testForward();
    testYoungest();
    testFull();
    testFence();
    testLock();
    testResetClears();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #80000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule